// File: doc/BRIEF.md
# Write-only I2C configuration slave

This block is the serial front end of an LED controller. It watches the two I2C bus lines, SCL and SDA. Both are sampled by a faster system clock and are assumed to be already synchronized. The block recognises START and STOP conditions and answers one fixed 7-bit device address. It accepts only write transfers.

After the device address, the first byte sets a register pointer. Every byte after that is stored at the pointer, and the pointer then moves to the next register. All 26 eight-bit control registers are presented side by side on one wide output bus, ready for the lighting logic to use.

The block acknowledges by asserting an open-drain output enable. The pad outside the block pulls SDA low while that enable is high. The block never stretches the clock and never drives read data.

Top module: `i2cw_cfg_slave`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears to 00h and `sda_oe` is low, and both stay so through the first edge after release.
- R2: A STOP (SDA rising while SCL is high) ends the transfer. Bytes clocked after it are neither acknowledged nor stored until a new START (SDA falling while SCL is high).
- R3: A first byte equal to 1110101 followed by a 0 direction bit (EAh on the wire, sent MSB first) is acknowledged.
- R4: A first byte whose 7 address bits differ from 1110101 is not acknowledged. Every byte that follows is then ignored until the next START.
- R5: A first byte carrying the matching address with direction bit 1 (EBh, a read) is not acknowledged. The bytes that follow it are ignored.
- R6: In an accepted transfer, the second byte sets the register pointer and the third byte is stored in that register. Both bytes are acknowledged.
- R7: Each further data byte in the same transfer is stored at the next register address.
- R8: A data byte aimed at an address above 19h is acknowledged but changes no register. Register n appears on `regs_flat[8n+7:8n]`.
- R9: A repeated START in the middle of a transfer abandons it and restarts address matching. The register pointer is loaded again from the byte after the new address.
- R10: `sda_oe` rises exactly one system clock after the clock edge that sees SCL fall at the end of an accepted eighth bit. It falls one system clock after the edge that sees SCL fall at the end of the ninth bit.
- R11: Register contents change only through an acknowledged data byte aimed at an address in 00h..19h, one clock after the acknowledge is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level, as seen on the wired bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| regs_flat | output | 8*NUM_REGS | All registers; register n at bits 8n+7..8n |

## Verification
A wrong phase or bit count shows up at the ports as a missing or extra acknowledge. That difference is visible one system clock after the SCL fall that ends the eighth bit. A corrupted register pointer shows up as a byte landing in the wrong slice of `regs_flat`, or landing where it should be discarded. That is visible two clocks after the same SCL fall. The reference model compares the whole register bus on every clock, so a stray write is caught in the cycle it lands. A foreign write is caught the same way even when no acknowledge check happens to cover it.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_DATA
  } phase_t;
endpackage

// File: rtl/i2cw_line_sense.sv
module i2cw_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    bus_start = scl_i & scl_q & sda_q & ~sda_i;
    bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2cw_byte_seq.sv
module i2cw_byte_seq
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h75
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] BITS_DONE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] PTR_MAX  = '1;

  phase_t            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        phase   <= PH_DEV;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (bus_stop) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && bit_cnt < BITS_DONE) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_i};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end else if (scl_fall && bit_cnt == BITS_DONE) begin
          bit_cnt <= ACK_SLOT;
          case (phase)
            PH_DEV: begin
              if (shreg == {DEV_ADDR, 1'b0}) sda_oe <= 1'b1;
              else                           phase  <= PH_IDLE;
            end
            PH_REG: begin
              ptr    <= shreg;
              sda_oe <= 1'b1;
            end
            default: begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= shreg;
              sda_oe  <= 1'b1;
              if (ptr != PTR_MAX) ptr <= ptr + BYTE_W'(1);
            end
          endcase
        end else if (scl_fall && bit_cnt == ACK_SLOT) begin
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
          if (phase == PH_DEV)      phase <= PH_REG;
          else if (phase == PH_REG) phase <= PH_DATA;
        end
      end
    end
  end

  assert_ack_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  assert_ack_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));
  assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (phase == PH_IDLE && !sda_oe));
  assert_start_rematch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (phase == PH_DEV && bit_cnt == '0));
  assert_own_addr_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEV && scl_fall && !bus_start && !bus_stop && bit_cnt == BITS_DONE
     && shreg == {DEV_ADDR, 1'b0}) |=> sda_oe);
  assert_foreign_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEV && scl_fall && bit_cnt == BITS_DONE
     && shreg[BYTE_W-1:1] != DEV_ADDR) |=> (!sda_oe && !wr_en));
  assert_read_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEV && scl_fall && bit_cnt == BITS_DONE && shreg[0]) |=> !sda_oe);
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != PTR_MAX) |-> (ptr == wr_addr + BYTE_W'(1)));
endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile
  import i2cw_pkg::*;
#(
  parameter int NUM_REGS = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] rd_flat
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [BYTE_W-1:0] LAST_ADDR = BYTE_W'(NUM_REGS - 1);

  logic [BYTE_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en && wr_addr <= LAST_ADDR) begin
      mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign rd_flat[g*BYTE_W +: BYTE_W] = mem[g];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_flat == '0));
  assert_oob_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > LAST_ADDR) |=> $stable(rd_flat));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_flat));
endmodule

// File: rtl/i2cw_cfg_slave.sv
module i2cw_cfg_slave
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h75,
  parameter int         NUM_REGS = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  logic              scl_rise;
  logic              scl_fall;
  logic              bus_start;
  logic              bus_stop;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  i2cw_line_sense u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2cw_byte_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  i2cw_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_flat (regs_flat)
  );
endmodule

// File: tb/sim_i2cw_cfg_slave.sv
module sim_i2cw_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HB         = 4;
  localparam int NREGS      = 26;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [NREGS*8-1:0] regs_flat;

  int n_tests = 0;
  int n_fail  = 0;
  int mism    = 0;
  bit done    = 1'b0;
  int exp_regs [NREGS];

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cw_cfg_slave u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .regs_flat (regs_flat)
  );

  // R11: register bus compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NREGS; i++)
        if (regs_flat[i*8 +: 8] != exp_regs[i][7:0]) mism++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(HB);
    scl_m = 1'b1; tick(HB);
    sda_m = 1'b0; tick(HB);
    scl_m = 1'b0; tick(HB);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(HB);
    scl_m = 1'b1; tick(HB);
    sda_m = 1'b1; tick(HB);
  endtask

  // idx < 0 means no store expected
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int idx, input string req);
    scl_m = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HB);
      scl_m = 1'b1; tick(HB);
      if (i == 0) chk(sda_oe == 1'b0, {req, " R10 no early ack"}, sda_oe, 0);
      scl_m = 1'b0;
    end
    tick(1);
    chk(sda_oe == exp_ack, {req, " R10 ack one clock after fall"}, sda_oe, exp_ack);
    @(posedge clk);
    if (exp_ack && idx >= 0 && idx < NREGS) exp_regs[idx] = b;
    @(negedge clk);
    sda_m = 1'b1; tick(HB-1);
    scl_m = 1'b1; tick(HB);
    chk(sda_bus == !exp_ack, {req, " ack level on bus"}, sda_bus, !exp_ack);
    scl_m = 1'b0; tick(1);
    chk(sda_oe == 1'b0, {req, " R10 release after ninth fall"}, sda_oe, 0);
  endtask

  task automatic check_reg(input int idx, input string req);
    chk(regs_flat[idx*8 +: 8] == exp_regs[idx][7:0], req,
        regs_flat[idx*8 +: 8], exp_regs[idx]);
  endtask

  task automatic check_all_zero(input string req);
    chk(regs_flat == '0 && sda_oe == 1'b0, req, int'(|regs_flat) + int'(sda_oe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=completion");
    report();
  end

  initial begin
    for (int i = 0; i < NREGS; i++) exp_regs[i] = 0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    check_all_zero("R1 reset state");

    // R3 / R6: single write
    bus_start();
    send_byte(8'hEA, 1'b1, -1, "R3 own address");
    send_byte(8'h01, 1'b1, -1, "R6 pointer byte");
    send_byte(8'h5A, 1'b1, 1,  "R6 data byte");
    bus_stop();
    check_reg(1, "R6 reg 01h");

    // R7 / R8: burst across the end of the map
    bus_start();
    send_byte(8'hEA, 1'b1, -1, "R3 own address");
    send_byte(8'h17, 1'b1, -1, "R7 pointer");
    send_byte(8'h11, 1'b1, 23, "R7 first");
    send_byte(8'h22, 1'b1, 24, "R7 second");
    send_byte(8'h33, 1'b1, 25, "R7 third");
    send_byte(8'h44, 1'b1, -1, "R8 1Ah acked");
    send_byte(8'h55, 1'b1, -1, "R8 1Bh acked");
    bus_stop();
    check_reg(24, "R7 reg 18h");
    check_reg(25, "R7 reg 19h");
    check_reg(0,  "R8 no wrap into 00h");

    // R4: foreign address
    bus_start();
    send_byte(8'hE8, 1'b0, -1, "R4 foreign address");
    send_byte(8'h02, 1'b0, -1, "R4 later byte");
    send_byte(8'h66, 1'b0, -1, "R4 later byte");
    send_byte(8'hEA, 1'b0, -1, "R4 own address without START");
    bus_stop();
    check_reg(2, "R4 reg 02h untouched");

    // R5: read request
    bus_start();
    send_byte(8'hEB, 1'b0, -1, "R5 read bit");
    send_byte(8'h03, 1'b0, -1, "R5 later byte");
    send_byte(8'h77, 1'b0, -1, "R5 later byte");
    bus_stop();
    check_reg(3, "R5 reg 03h untouched");

    // R9: repeated START
    bus_start();
    send_byte(8'hEA, 1'b1, -1, "R9 address");
    send_byte(8'h03, 1'b1, -1, "R9 first pointer");
    bus_start();
    send_byte(8'hEA, 1'b1, -1, "R9 address again");
    send_byte(8'h04, 1'b1, -1, "R9 new pointer");
    send_byte(8'h77, 1'b1, 4,  "R9 data");
    bus_stop();
    check_reg(3, "R9 old pointer unused");
    check_reg(4, "R9 reg 04h");
    bus_start();
    send_byte(8'hEA, 1'b1, -1, "R9 address");
    send_byte(8'h05, 1'b1, -1, "R9 pointer");
    bus_start();
    send_byte(8'hE8, 1'b0, -1, "R9 rematch foreign");
    send_byte(8'h99, 1'b0, -1, "R9 ignored data");
    bus_stop();
    check_reg(5, "R9 reg 05h untouched");

    // R2: STOP ends the transfer
    bus_start();
    send_byte(8'hEA, 1'b1, -1, "R2 address");
    send_byte(8'h06, 1'b1, -1, "R2 pointer");
    send_byte(8'h10, 1'b1, 6,  "R2 data");
    bus_stop();
    send_byte(8'hEA, 1'b0, -1, "R2 after STOP");
    send_byte(8'h06, 1'b0, -1, "R2 after STOP");
    send_byte(8'h99, 1'b0, -1, "R2 after STOP");
    scl_m = 1'b1; tick(HB);
    check_reg(6, "R2 reg 06h kept");

    // R1: reset in service clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    for (int i = 0; i < NREGS; i++) exp_regs[i] = 0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check_all_zero("R1 reset after writes");

    chk(mism == 0, "R11 register bus matched model every clock", mism, 0);
    report();
  end
endmodule